// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block drives two pulse-width-modulated pins from one shared timebase. A prescaler turns the system clock into ticks lasting either one or four clocks. A base divider then counts a programmable number of ticks to form one base period. A 256-step cycle counter advances once per base period. Each channel compares the cycle step with its own 8-bit duty value. The pin is high from the start of the cycle up to and including the step equal to the duty value, and low for the rest of the cycle.

Software writes the period and both duty values through a simple strobe port. The written values and the clock-select input go into shadow copies only at a cycle boundary. This keeps pulses whole when settings change. An enabled channel drives its pin as an output whatever the port direction says. A disabled channel passes the normal port data and direction straight through, with one register stage.

The timebase is sequenced by a two-state machine. Reset puts it in `TB_ARM`. In `TB_ARM` the shadow copies are loaded once and the counters stay at zero. The transition ARM→RUN is taken unconditionally on the next clock. In `TB_RUN` the counters advance. The RUN→RUN transition repeats each clock, and the shadow copies reload whenever step 255 ends. Only reset returns the machine to `TB_ARM`.

Top module: `dual_pwm_gen`

## Requirements
- R1: A synchronous active-high reset drives `pin_out` and `pin_oe` low, sets the period register to 1, the duty registers to 0 and the clock select to 1x.
- R2: With the clock select at 0, one PWM cycle lasts 256×(P+1) system clocks, where P is the period register value.
- R3: With `clk_quad` at 1, every tick lasts 4 system clocks, so a cycle lasts 1024×(P+1) clocks.
- R4: An enabled channel's pin goes high at the start of each cycle and stays high for (D+1)×(P+1) ticks, where D is the channel's duty value.
- R5: A duty value of 255 keeps the pin high for the whole cycle.
- R6: A period value of 0 behaves exactly like a period value of 1.
- R7: Writes use address 0 for the period, address 1 for the channel 0 duty and address 2 for the channel 1 duty. A written value, and the clock select, take effect only from the next cycle boundary.
- R8: While a channel's bit in `pwm_en` is 1, its `pin_oe` bit is 1 even if its `port_dir` bit is 0.
- R9: While a channel is disabled, its `pin_out` bit equals `port_data` and its `pin_oe` bit equals `port_dir`, one clock after they change.
- R10: Both channels share one cycle length, and each channel's high time depends only on its own duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 period, 1 duty ch0, 2 duty ch1 |
| wr_data | input | 8 | Write data |
| clk_quad | input | 1 | 1 selects four system clocks per tick |
| pwm_en | input | 2 | Per-channel PWM enable |
| port_dir | input | 2 | Port direction per pin, 1 = output |
| port_data | input | 2 | Port data per pin |
| pin_out | output | 2 | Pin level |
| pin_oe | output | 2 | Pin output enable |

## Verification
Every pin result is registered once after the compare, so a change of `port_data`, `port_dir` or `pwm_en` shows at the ports on the next clock edge. The bench samples on the falling edge after that rising edge. A register write lands one clock after the strobe but is used only from the next cycle boundary. Because of this, each measurement skips one rising pin edge to get past any partly old cycle, realigns on the next rising edge, and then counts clocks to the following rising edge. The cycle lengths and high times it counts are compared with 256×(P+1)×m and (D+1)×(P+1)×m. The deferral test writes a new duty value part-way through a cycle. It then checks that the next rising edge arrives exactly on the old schedule, and that the new high time appears only in the cycle after it.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic {
        TB_ARM,
        TB_RUN
    } tb_state_e;

    localparam int QUAD_DIV = 4;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter int AW  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic                    quad_in,
    input  logic                    load,
    output logic [DW-1:0]           per_sh,
    output logic [NCH-1:0][DW-1:0]  duty_sh,
    output logic                    quad_sh
);
    logic [DW-1:0]          per_q;
    logic [NCH-1:0][DW-1:0] duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q   <= DW'(1);
            per_sh  <= DW'(1);
            quad_sh <= 1'b0;
        end else begin
            if (wr_en && wr_addr == '0) per_q <= wr_data;
            if (load) begin
                per_sh  <= per_q;
                quad_sh <= quad_in;
            end
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_duty
        always_ff @(posedge clk) begin
            if (rst) begin
                duty_q[k]  <= '0;
                duty_sh[k] <= '0;
            end else begin
                if (wr_en && wr_addr == AW'(k + 1)) duty_q[k] <= wr_data;
                if (load) duty_sh[k] <= duty_q[k];
            end
        end

        AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
            !load |=> $stable(duty_sh[k])); // R7
    end

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(per_sh) && $stable(quad_sh))); // R7
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          quad,
    input  logic [DW-1:0] per,
    output logic [SW-1:0] step,
    output logic          load
);
    localparam logic [SW-1:0] STEP_LAST = '1;
    localparam int            PW        = $clog2(QUAD_DIV);
    localparam logic [PW-1:0] PRE_LAST  = PW'(QUAD_DIV - 1);

    tb_state_e     state, state_nx;
    logic [PW-1:0] pre;
    logic [DW-1:0] div;
    logic [DW-1:0] per_eff;
    logic          tick, base_end, wrap, run;

    always_ff @(posedge clk) begin
        if (rst) state <= TB_ARM;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TB_ARM: state_nx = TB_RUN;
            TB_RUN: state_nx = TB_RUN;
        endcase
    end

    always_comb begin
        run      = (state == TB_RUN);
        per_eff  = (per == '0) ? DW'(1) : per;
        tick     = !quad || (pre == PRE_LAST);
        base_end = run && tick && (div == per_eff);
        wrap     = base_end && (step == STEP_LAST);
        load     = (state == TB_ARM) || wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre  <= '0;
            div  <= '0;
            step <= '0;
        end else if (run) begin
            pre  <= quad ? pre + 1'b1 : '0;
            div  <= base_end ? '0 : (tick ? div + 1'b1 : div);
            step <= base_end ? step + 1'b1 : step;
        end
    end

    AST_DIV_BOUND: assert property (@(posedge clk) disable iff (rst)
        div <= per_eff); // R6
    AST_STEP_SEQ: assert property (@(posedge clk) disable iff (rst)
        (step != $past(step)) |-> (step == SW'($past(step) + 1'b1))); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (load && run) |=> (step == '0)); // R7
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          dir,
    input  logic          data,
    input  logic [DW-1:0] step,
    input  logic [DW-1:0] duty,
    output logic          pin,
    output logic          oe
);
    logic level;

    always_comb level = (step <= duty);

    always_ff @(posedge clk) begin
        if (rst) begin
            pin <= 1'b0;
            oe  <= 1'b0;
        end else if (en) begin
            pin <= level;
            oe  <= 1'b1;
        end else begin
            pin <= data;
            oe  <= dir;
        end
    end

    AST_FORCE_OE: assert property (@(posedge clk) disable iff (rst)
        en |=> oe); // R8
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (en && duty == '1) |=> pin); // R5
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen #(
    parameter int NCH = 2,
    parameter int DW  = 8,
    parameter int AW  = $clog2(NCH + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           clk_quad,
    input  logic [NCH-1:0] pwm_en,
    input  logic [NCH-1:0] port_dir,
    input  logic [NCH-1:0] port_data,
    output logic [NCH-1:0] pin_out,
    output logic [NCH-1:0] pin_oe
);
    logic [DW-1:0]          per_sh;
    logic [NCH-1:0][DW-1:0] duty_sh;
    logic                   quad_sh;
    logic [DW-1:0]          step;
    logic                   load;

    pwm_regs #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .quad_in(clk_quad), .load(load),
        .per_sh(per_sh), .duty_sh(duty_sh), .quad_sh(quad_sh)
    );

    pwm_timebase #(.DW(DW), .SW(DW)) u_tb (
        .clk(clk), .rst(rst), .quad(quad_sh), .per(per_sh),
        .step(step), .load(load)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        pwm_chan #(.DW(DW)) u_ch (
            .clk(clk), .rst(rst), .en(pwm_en[c]), .dir(port_dir[c]),
            .data(port_data[c]), .step(step), .duty(duty_sh[c]),
            .pin(pin_out[c]), .oe(pin_oe[c])
        );
    end
endmodule

// File: tb/dual_pwm_gen_test.sv
module dual_pwm_gen_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic       clk_quad;
    logic [1:0] pwm_en, port_dir, port_data;
    logic [1:0] pin_out, pin_oe;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    dual_pwm_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .clk_quad(clk_quad), .pwm_en(pwm_en),
        .port_dir(port_dir), .port_data(port_data),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise(input int ch, output int n, output int hi);
        logic prev, cur;
        prev = pin_out[ch];
        n = 0; hi = 0;
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            cur = pin_out[ch];
            n++;
            if (cur && !prev) return;
            if (cur) hi++;
            prev = cur;
        end
        errors++; checks++;
        $display("FAIL R4 no rising edge on ch%0d actual=0 expected=1", ch);
    endtask

    task automatic meas(input int ch, output int per, output int hi);
        int n, h;
        wait_rise(ch, n, h);
        wait_rise(ch, n, h);
        wait_rise(ch, n, h);
        per = n;
        hi  = h + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int per, hi, n, h, lows, pe, m;
        int duties[2] = '{5, 254};
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        clk_quad = 1'b0; pwm_en = '0; port_dir = '0; port_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 pin_out in reset", pin_out, 0);
        chk("R1 pin_oe in reset", pin_oe, 0);
        rst = 1'b0;

        port_dir = 2'b11; port_data = 2'b01;
        @(negedge clk);
        chk("R9 pin_out follows data", pin_out, 1);
        chk("R9 pin_oe follows dir", pin_oe, 3);
        port_data = 2'b10;
        @(negedge clk);
        chk("R9 pin_out follows new data", pin_out, 2);

        pwm_en = 2'b11; port_dir = 2'b00;
        @(negedge clk);
        chk("R8 oe forced with dir input", pin_oe, 3);

        meas(0, per, hi);
        chk("R1 default period 1 cycle length", per, 512);
        chk("R1 default duty 0 high time", hi, 2);

        for (int p = 0; p < 3; p++) begin
            for (int q = 0; q < 2; q++) begin
                for (int di = 0; di < 2; di++) begin
                    clk_quad = q[0];
                    wr(0, p);
                    wr(1, duties[di]);
                    pe = (p == 0) ? 1 : p;
                    m  = q ? 4 : 1;
                    meas(0, per, hi);
                    chk(p == 0 ? "R6 cycle length" : (q ? "R3 cycle length" : "R2 cycle length"),
                        per, 256 * (pe + 1) * m);
                    chk("R4 high time", hi, (duties[di] + 1) * (pe + 1) * m);
                end
            end
        end

        clk_quad = 1'b0;
        wr(0, 1); wr(1, 20); wr(2, 255);
        meas(0, per, hi);
        chk("R10 ch0 high with ch1 full", hi, 42);
        lows = 0;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (!pin_out[1]) lows++;
        end
        chk("R5 ch1 low samples at duty 255", lows, 0);
        wr(2, 60);
        meas(1, per, hi);
        chk("R10 ch1 cycle length", per, 512);
        chk("R10 ch1 high time", hi, 122);
        meas(0, per, hi);
        chk("R10 ch0 unaffected by ch1", hi, 42);

        wr(1, 10);
        meas(0, per, hi);
        chk("R4 duty 10 high time", hi, 22);
        repeat (100) @(negedge clk);
        wr(1, 100);
        wait_rise(0, n, h);
        chk("R7 mid-cycle write keeps cycle", n, 410);
        wait_rise(0, n, h);
        chk("R7 new duty from next cycle", h + 1, 202);

        pwm_en = 2'b00; port_dir = 2'b01; port_data = 2'b01;
        @(negedge clk);
        chk("R9 oe after disable", pin_oe, 1);
        chk("R9 pin after disable", pin_out, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule